// File: doc/BRIEF.md
# Dual-Area LCD Display Memory

This block is the on-chip display RAM behind an LCD driver. It holds 402 bytes, organised as six pages of 67 bytes. A CPU port decodes the fixed window F800H to FD42H and gives byte writes and one-cycle registered byte reads, so software can do read-modify-write on single dots. The high address byte selects the page and the low byte selects the column. Column offsets 43H to FFH inside a page are holes in the window.

A scan port takes a common line index and a segment index from the LCD timing logic. It returns the dot bit one cycle later. Each byte is one segment column across the commons of a page.

- In 5x8 font mode, each byte packs 8 commons.
- In 5x5 font mode, each byte packs 5 commons, and the upper three bits become plain RAM.

At the three lower duties, the memory holds two screen areas, and an area-select input chooses which one is shown. The block latches that choice only on a frame-start pulse. Accesses inside the window always claim the bus, even when an external memory expansion is enabled.

Top module: `lcd_dmem`

## Requirements
- R1: A byte written at address F800H + 100H·p + o (page p in 0..5, offset o in 00H..42H) is returned on `cpu_rdata_o` at the clock edge that follows a read request to that address. Without a read request, `cpu_rdata_o` holds its value.
- R2: Inside the window, addresses with offset 43H..FFH are holes. A read of a hole returns 00H, and a write to a hole changes no stored byte.
- R3: For a request to any address from F800H to FD42H, `cpu_hit_o` is 1 and `ext_cs_o` is 0, whatever the value of `ext_en_i`. Outside that range:
  - `cpu_hit_o` is 0.
  - `ext_cs_o` equals the request AND `ext_en_i`.
  - A read returns 00H.
- R4: With `font_sel_i`=0, the dot for common c and segment s is bit (c mod 8) of the byte at page (area base + c/8), offset s. The dot appears on `scan_dot_o` one clock after the indices are presented. A 1 bit means the dot is on.
- R5: With `font_sel_i`=1, the dot for common c and segment s is bit (c mod 5) of the byte at page (area base + c/5), offset s. Bits 5..7 are never scanned.
- R6: The `duty_i` encoding is 0 = 1/8 (8 commons, 1 page per area), 1 = 1/16 (16, 2), 2 = 1/17 (17, 3) and 3 = 1/32 (32, 4). A scan returns 0 in any of these cases:
  - the common index is not below the common count;
  - the segment index is 67 or more;
  - the page offset is not below the area page count.
- R7: At duty code 3, the area base is page 0. At the other duties, the area base is page 0 for area 0 and page 3 for area 1.
- R8: The area in use is latched from `area_sel_i` only in a cycle where `frame_start_i` is 1. The lookup presented in that same cycle already uses the new value, and changes at other times have no effect.
- R9: When a CPU write and a scan hit the same byte in the same cycle, the write completes and the scan returns the byte's old value.
- R10: After reset, `cpu_rdata_o` and `scan_dot_o` are 0 and area 0 is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | CPU access request |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 16 | CPU byte address |
| cpu_wdata_i | input | 8 | CPU write data |
| ext_en_i | input | 1 | External memory expansion enabled |
| cpu_rdata_o | output | 8 | Registered read data |
| cpu_hit_o | output | 1 | Access falls in the display window |
| ext_cs_o | output | 1 | Access is forwarded to external memory |
| duty_i | input | 2 | Drive duty code |
| font_sel_i | input | 1 | 0 = 5x8 font layout, 1 = 5x5 font layout |
| area_sel_i | input | 1 | Requested display area |
| frame_start_i | input | 1 | First scan cycle of a frame |
| scan_com_i | input | 6 | Common line index |
| scan_seg_i | input | 7 | Segment index |
| scan_dot_o | output | 1 | Dot state, one cycle after the indices |

## Verification
The bench builds the block with its default parameters:
- six pages of 67 bytes;
- window base F800H;
- area 1 at page 3;
- 6-bit common and 7-bit segment indices.

This lets a single run reach every duty code and both font layouts. It also reaches common and segment indices just past every limit, the holes at the end of each page, the first address past the window, and the page-3 area that only the lower duties use. A bench model of the storage predicts each scan and read. Collisions between a write and a scan on the same byte, and area changes both mid-frame and at frame start, come up in random traffic and are also forced directly.

// File: rtl/lcd_dmem_pkg.sv
package lcd_dmem_pkg;

  typedef enum logic [1:0] {
    DUTY_8  = 2'd0,
    DUTY_16 = 2'd1,
    DUTY_17 = 2'd2,
    DUTY_32 = 2'd3
  } duty_e;

  function automatic int duty_commons(duty_e d);
    case (d)
      DUTY_8:  return 8;
      DUTY_16: return 16;
      DUTY_17: return 17;
      default: return 32;
    endcase
  endfunction

  function automatic int duty_pages(duty_e d);
    case (d)
      DUTY_8:  return 1;
      DUTY_16: return 2;
      DUTY_17: return 3;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/lcd_dmem_cpu_dec.sv
module lcd_dmem_cpu_dec #(
  parameter logic [15:0] BASE_ADDR  = 16'hF800,
  parameter int          NUM_PAGES  = 6,
  parameter int          PAGE_BYTES = 67,
  parameter int          PG_W       = 3
) (
  input  logic [15:0]     addr_i,
  output logic            in_win_o,
  output logic            gap_o,
  output logic            valid_o,
  output logic [PG_W-1:0] page_o,
  output logic [7:0]      col_o
);

  localparam logic [15:0] LAST_ADDR = BASE_ADDR + 16'((NUM_PAGES - 1) * 256 + PAGE_BYTES - 1);

  always_comb begin
    in_win_o = (addr_i >= BASE_ADDR) && (addr_i <= LAST_ADDR);
    col_o    = addr_i[7:0];
    gap_o    = in_win_o && (int'(addr_i[7:0]) >= PAGE_BYTES);
    valid_o  = in_win_o && !gap_o;
    page_o   = valid_o ? PG_W'(addr_i[15:8] - BASE_ADDR[15:8]) : '0;
  end

endmodule

// File: rtl/lcd_dmem_scan_map.sv
module lcd_dmem_scan_map
  import lcd_dmem_pkg::*;
#(
  parameter int NUM_PAGES  = 6,
  parameter int PAGE_BYTES = 67,
  parameter int AREA1_PAGE = 3,
  parameter int COM_W      = 6,
  parameter int SEG_W      = 7,
  parameter int PG_W       = 3
) (
  input  logic [COM_W-1:0] com_i,
  input  logic [SEG_W-1:0] seg_i,
  input  duty_e            duty_i,
  input  logic             font_i,
  input  logic             area_i,
  output logic             valid_o,
  output logic [PG_W-1:0]  page_o,
  output logic [SEG_W-1:0] col_o,
  output logic [2:0]       bit_o
);

  int ncom, npg, pofs, bsel, base, pg;

  always_comb begin
    ncom = duty_commons(duty_i);
    npg  = duty_pages(duty_i);
    // 5x5 layout packs five commons per byte
    if (font_i) begin
      pofs = int'(com_i) / 5;
      bsel = int'(com_i) % 5;
    end else begin
      pofs = int'(com_i) / 8;
      bsel = int'(com_i) % 8;
    end
    base    = (area_i && duty_i != DUTY_32) ? AREA1_PAGE : 0;
    pg      = base + pofs;
    valid_o = (int'(com_i) < ncom) && (int'(seg_i) < PAGE_BYTES) &&
              (pofs < npg) && (pg < NUM_PAGES);
    page_o  = valid_o ? PG_W'(pg) : '0;
    col_o   = valid_o ? seg_i : '0;
    bit_o   = 3'(bsel);
  end

endmodule

// File: rtl/lcd_dmem_array.sv
module lcd_dmem_array #(
  parameter int DEPTH = 402,
  parameter int IDX_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [7:0]       wr_data_i,
  input  logic             rd_en_i,
  input  logic             rd_valid_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [7:0]       rd_data_o,
  input  logic             sc_valid_i,
  input  logic [IDX_W-1:0] sc_idx_i,
  input  logic [2:0]       sc_bit_i,
  output logic             sc_dot_o
);

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  // both ports sample pre-write contents at the edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o <= '0;
      sc_dot_o  <= 1'b0;
    end else begin
      if (rd_en_i) rd_data_o <= rd_valid_i ? mem_q[rd_idx_i] : 8'h00;
      sc_dot_o <= sc_valid_i ? mem_q[sc_idx_i][sc_bit_i] : 1'b0;
    end
  end

endmodule

// File: rtl/lcd_dmem.sv
module lcd_dmem
  import lcd_dmem_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR  = 16'hF800,
  parameter int          NUM_PAGES  = 6,
  parameter int          PAGE_BYTES = 67,
  parameter int          AREA1_PAGE = 3,
  parameter int          COM_W      = 6,
  parameter int          SEG_W      = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpu_req_i,
  input  logic             cpu_we_i,
  input  logic [15:0]      cpu_addr_i,
  input  logic [7:0]       cpu_wdata_i,
  input  logic             ext_en_i,
  output logic [7:0]       cpu_rdata_o,
  output logic             cpu_hit_o,
  output logic             ext_cs_o,
  input  logic [1:0]       duty_i,
  input  logic             font_sel_i,
  input  logic             area_sel_i,
  input  logic             frame_start_i,
  input  logic [COM_W-1:0] scan_com_i,
  input  logic [SEG_W-1:0] scan_seg_i,
  output logic             scan_dot_o
);

  localparam int          DEPTH     = NUM_PAGES * PAGE_BYTES;
  localparam int          IDX_W     = $clog2(DEPTH);
  localparam int          PG_W      = $clog2(NUM_PAGES);
  localparam logic [15:0] LAST_ADDR = BASE_ADDR + 16'((NUM_PAGES - 1) * 256 + PAGE_BYTES - 1);

  logic            dec_in_win, dec_gap, dec_valid;
  logic [PG_W-1:0] dec_page;
  logic [7:0]      dec_col;

  lcd_dmem_cpu_dec #(
    .BASE_ADDR (BASE_ADDR),
    .NUM_PAGES (NUM_PAGES),
    .PAGE_BYTES(PAGE_BYTES),
    .PG_W      (PG_W)
  ) u_dec (
    .addr_i  (cpu_addr_i),
    .in_win_o(dec_in_win),
    .gap_o   (dec_gap),
    .valid_o (dec_valid),
    .page_o  (dec_page),
    .col_o   (dec_col)
  );

  // window always claimed internally, even with expansion enabled
  assign cpu_hit_o = cpu_req_i && dec_in_win;
  assign ext_cs_o  = cpu_req_i && ext_en_i && !dec_in_win;

  logic             area_q, area_eff;
  duty_e            duty;
  logic             sc_valid;
  logic [PG_W-1:0]  sc_page;
  logic [SEG_W-1:0] sc_col;
  logic [2:0]       sc_bit;

  assign duty = duty_e'(duty_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            area_q <= 1'b0;
    else if (frame_start_i) area_q <= area_sel_i;
  end

  assign area_eff = frame_start_i ? area_sel_i : area_q;

  lcd_dmem_scan_map #(
    .NUM_PAGES (NUM_PAGES),
    .PAGE_BYTES(PAGE_BYTES),
    .AREA1_PAGE(AREA1_PAGE),
    .COM_W     (COM_W),
    .SEG_W     (SEG_W),
    .PG_W      (PG_W)
  ) u_map (
    .com_i  (scan_com_i),
    .seg_i  (scan_seg_i),
    .duty_i (duty),
    .font_i (font_sel_i),
    .area_i (area_eff),
    .valid_o(sc_valid),
    .page_o (sc_page),
    .col_o  (sc_col),
    .bit_o  (sc_bit)
  );

  logic [IDX_W-1:0] cpu_idx, sc_idx;

  assign cpu_idx = IDX_W'(dec_page) * IDX_W'(PAGE_BYTES) + IDX_W'(dec_col);
  assign sc_idx  = IDX_W'(sc_page) * IDX_W'(PAGE_BYTES) + IDX_W'(sc_col);

  lcd_dmem_array #(
    .DEPTH(DEPTH),
    .IDX_W(IDX_W)
  ) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (cpu_req_i && cpu_we_i && dec_valid),
    .wr_idx_i  (cpu_idx),
    .wr_data_i (cpu_wdata_i),
    .rd_en_i   (cpu_req_i && !cpu_we_i),
    .rd_valid_i(dec_valid),
    .rd_idx_i  (cpu_idx),
    .rd_data_o (cpu_rdata_o),
    .sc_valid_i(sc_valid),
    .sc_idx_i  (sc_idx),
    .sc_bit_i  (sc_bit),
    .sc_dot_o  (scan_dot_o)
  );

  // R3
  hit_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_hit_o |-> !ext_cs_o);

  // R3
  win_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && (cpu_addr_i < BASE_ADDR || cpu_addr_i > LAST_ADDR)) |-> !cpu_hit_o);

  // R2
  gap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_req_i && !cpu_we_i && dec_gap) |=> (cpu_rdata_o == 8'h00));

  // R1
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cpu_req_i && !cpu_we_i) |=> $stable(cpu_rdata_o));

  // R6
  com_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(scan_com_i) >= duty_commons(duty)) |=> !scan_dot_o);

endmodule

// File: tb/lcd_dmem_bench.sv
module lcd_dmem_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0, ext_en = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic        cpu_hit, ext_cs;
  logic [1:0]  duty = '0;
  logic        font_sel = 1'b0, area_sel = 1'b0, frame_start = 1'b0;
  logic [5:0]  scan_com = 6'd40;
  logic [6:0]  scan_seg = '0;
  logic        scan_dot;

  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;
  logic [7:0] mem_m [6][67];
  bit   area_m = 1'b0;

  always #5 clk = ~clk;

  lcd_dmem u_lcd_dmem (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .ext_en_i(ext_en),
    .cpu_rdata_o(cpu_rdata), .cpu_hit_o(cpu_hit), .ext_cs_o(ext_cs),
    .duty_i(duty), .font_sel_i(font_sel), .area_sel_i(area_sel),
    .frame_start_i(frame_start), .scan_com_i(scan_com), .scan_seg_i(scan_seg),
    .scan_dot_o(scan_dot)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit in_win(logic [15:0] a);
    return a >= 16'hF800 && a <= 16'hFD42;
  endfunction

  function automatic bit is_gap(logic [15:0] a);
    return in_win(a) && int'(a[7:0]) >= 67;
  endfunction

  function automatic bit dot_valid(int com, int seg, int d, bit font);
    int ncom, npg, pofs;
    ncom = (d == 0) ? 8 : (d == 1) ? 16 : (d == 2) ? 17 : 32;
    npg  = (d == 0) ? 1 : (d == 1) ? 2 : (d == 2) ? 3 : 4;
    pofs = font ? com / 5 : com / 8;
    return com < ncom && seg < 67 && pofs < npg;
  endfunction

  function automatic bit exp_dot(int com, int seg, int d, bit font, bit area);
    int pofs, b, base;
    if (!dot_valid(com, seg, d, font)) return 1'b0;
    pofs = font ? com / 5 : com / 8;
    b    = font ? com % 5 : com % 8;
    base = (d != 3 && area) ? 3 : 0;
    return mem_m[base + pofs][seg][b];
  endfunction

  // one cycle: check comb outputs, predict, clock, update model, check registered outputs
  task automatic step(string tag);
    bit rd, w, ed, aeff;
    logic [7:0] er;
    string ct, st;
    #1;
    w = in_win(cpu_addr);
    chk(cpu_hit == (cpu_req && w), "R3 hit", int'(cpu_hit), int'(cpu_req && w));
    chk(ext_cs == (cpu_req && ext_en && !w), "R3 ext_cs", int'(ext_cs), int'(cpu_req && ext_en && !w));
    rd = cpu_req && !cpu_we;
    er = (w && !is_gap(cpu_addr)) ? mem_m[int'(cpu_addr[15:8]) - 'hF8][cpu_addr[7:0]] : 8'h00;
    ct = is_gap(cpu_addr) ? "R2 read" : w ? "R1 read" : "R3 read";
    aeff = frame_start ? area_sel : area_m;
    ed = exp_dot(int'(scan_com), int'(scan_seg), int'(duty), font_sel, aeff);
    if (tag != "") st = tag;
    else if (!dot_valid(int'(scan_com), int'(scan_seg), int'(duty), font_sel)) st = "R6 scan";
    else st = font_sel ? "R5 scan" : "R4 scan";
    @(posedge clk);
    if (cpu_req && cpu_we && w && !is_gap(cpu_addr))
      mem_m[int'(cpu_addr[15:8]) - 'hF8][cpu_addr[7:0]] = cpu_wdata;
    if (frame_start) area_m = area_sel;
    @(negedge clk);
    if (rd) chk(cpu_rdata == er, ct, int'(cpu_rdata), int'(er));
    chk(scan_dot == ed, st, int'(scan_dot), int'(ed));
  endtask

  task automatic cpu_set(bit req, bit we, logic [15:0] a, logic [7:0] d);
    cpu_req = req; cpu_we = we; cpu_addr = a; cpu_wdata = d;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    chk(cpu_rdata == 8'h00, "R10 rdata", int'(cpu_rdata), 0);
    chk(scan_dot == 1'b0, "R10 dot", int'(scan_dot), 0);

    // fill all bytes (R1)
    for (int p = 0; p < 6; p++)
      for (int o = 0; o < 67; o++) begin
        cpu_set(1'b1, 1'b1, 16'hF800 + 16'(p * 256 + o), 8'($urandom));
        step("R1");
      end

    // R10: area 0 still latched, area_sel change without frame start ignored
    cpu_set(1'b0, 1'b0, 16'h0000, 8'h00);
    duty = 2'd0; font_sel = 1'b0; area_sel = 1'b1;
    for (int c = 0; c < 8; c++) begin
      scan_com = 6'(c); scan_seg = 7'd10;
      step("R10 area latch");
    end

    // R7/R8: latch area 1 at 1/16, then mid-frame change ignored
    duty = 2'd1; frame_start = 1'b1; area_sel = 1'b1; scan_com = 6'd9; scan_seg = 7'd3;
    step("R8 frame start");
    frame_start = 1'b0; area_sel = 1'b0;
    for (int c = 0; c < 16; c += 3) begin
      scan_com = 6'(c); scan_seg = 7'd66;
      step("R8 mid-frame");
    end
    // R7: duty 1/32 ignores area 1
    duty = 2'd3; frame_start = 1'b1; area_sel = 1'b1;
    for (int c = 0; c < 32; c += 5) begin
      scan_com = 6'(c); scan_seg = 7'd20;
      step("R7 duty32 base");
      frame_start = 1'b0;
    end

    // R9: collision, write flips scanned bit
    duty = 2'd0; font_sel = 1'b0; frame_start = 1'b1; area_sel = 1'b0;
    scan_com = 6'd3; scan_seg = 7'd5;
    cpu_set(1'b1, 1'b1, 16'hF805, mem_m[0][5] ^ 8'h08);
    step("R9 collision old");
    frame_start = 1'b0;
    cpu_set(1'b1, 1'b0, 16'hF805, 8'h00);
    step("R9 after write");

    // R2: hole write must not alias, then read hole and neighbour
    cpu_set(1'b1, 1'b1, 16'hF943, 8'hFF); step("R2");
    cpu_set(1'b1, 1'b0, 16'hF943, 8'h00); step("R2");
    cpu_set(1'b1, 1'b0, 16'hF942, 8'h00); step("R2");
    cpu_set(1'b1, 1'b0, 16'hF900, 8'h00); step("R2");
    // R3: boundaries with expansion enabled
    ext_en = 1'b1;
    cpu_set(1'b1, 1'b0, 16'hFD42, 8'h00); step("R3");
    cpu_set(1'b1, 1'b0, 16'hFD43, 8'h00); step("R3");
    cpu_set(1'b1, 1'b0, 16'hF7FF, 8'h00); step("R3");
    cpu_set(1'b1, 1'b0, 16'hF800, 8'h00); step("R3");

    // random traffic
    for (int i = 0; i < 5000; i++) begin
      int k;
      logic [15:0] a;
      k = int'($urandom_range(0, 99));
      if (k < 70) a = 16'hF800 + 16'($urandom_range(0, 5) * 256 + $urandom_range(0, 66));
      else if (k < 85) a = 16'hF800 + 16'($urandom_range(0, 5) * 256 + $urandom_range(67, 255));
      else a = 16'($urandom);
      cpu_set(1'($urandom), 1'($urandom), a, 8'($urandom));
      ext_en      = 1'($urandom);
      frame_start = ($urandom_range(0, 15) == 0);
      area_sel    = 1'($urandom);
      if ($urandom_range(0, 31) == 0) begin
        duty = 2'($urandom); font_sel = 1'($urandom);
      end
      scan_com = 6'($urandom_range(0, 35));
      scan_seg = 7'($urandom_range(0, 69));
      step("");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule